// File: doc/BRIEF.md
# Page Write Latch and Commit Sequencer

This block sits behind the serial protocol controller of a byte-addressed non-volatile memory. It gathers the data bytes of one write command into a page-sized latch. A command opens with a start address. Each data byte then lands at the current in-row offset, and only the low offset bits advance, so the fill wraps inside one row. Every latch entry carries its own valid flag.

The latch is committed only when the controller reports a stop in the bit slot right after an acknowledged data byte. At least one entry must also be valid. A stop in any other slot discards the latch, and so does a fresh command start. After a commit the block raises `busy` for a fixed number of system clock cycles, set by a parameter. In the first cycles of that window it walks the entries in ascending offset order and issues one array write strobe for each valid entry. At the end of the window it clears the valid flags.

While `busy` is high every input is ignored. The controller uses `busy` to leave even its own select byte unacknowledged, which lets a bus master poll for completion. A write-protect input keeps bytes out of the latch, so nothing protected ever reaches the array.

Top module: `pw_commit_seq`

## Requirements
- R1: A byte accepted while idle with `wp` low is stored at offset `ofs` of the current row. Its commit writes address `{row, ofs}` with that byte as data. The row is `start_addr[ADDR_W-1:5]` and the starting offset is `start_addr[4:0]`.
- R2: Each byte that is not ignored advances only the 5-bit offset, from 31 back to 0. The row never changes. A later byte that lands on the same offset replaces the earlier one.
- R3: A commit starts only when `stop_in_slot` is seen while idle with at least one valid entry. A `stop_other` pulse or a new `cmd_start` while idle empties the latch, so no write and no busy window follow.
- R4: While `busy` is high, `cmd_start`, `byte_valid`, `stop_in_slot` and `stop_other` have no effect on the latch, the pointer or the timer.
- R5: A byte presented with `wp` high still advances the offset but is not stored. With no valid entry, a later `stop_in_slot` starts no busy window.
- R6: `busy` rises in the cycle after the accepted stop and stays high for exactly `TW_CYCLES+1` cycles.
- R7: During the first `PAGE_BYTES` busy cycles, one `arr_we` strobe is issued for each valid entry, in ascending offset order. No strobe is issued for an empty entry or outside the busy window. All valid flags are cleared when busy ends.
- R8: A byte presented in the same cycle as an accepted `stop_in_slot` is part of that commit.
- R9: After reset, `busy` and `arr_we` are low and the latch is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Pulse: a write command begins, load `start_addr` |
| start_addr | input | ADDR_W | Array address of the first data byte |
| byte_valid | input | 1 | Pulse: one received data byte |
| byte_data | input | DATA_W | Data byte qualified by `byte_valid` |
| wp | input | 1 | Write protect; high keeps bytes out of the latch |
| stop_in_slot | input | 1 | Pulse: stop seen in the slot right after a data-byte acknowledge |
| stop_other | input | 1 | Pulse: stop seen in any other slot |
| busy | output | 1 | Internal write cycle in progress; the bus is ignored |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
Two functions can fall in the same cycle: storing a data byte and accepting the commit stop. The bench provokes this by raising `byte_valid` and `stop_in_slot` on one clock edge. It then requires the array write log to contain both the earlier byte and the simultaneous one, at consecutive offsets. A design that samples the valid flags before the new byte lands would lose the second write and be caught. A related case, a stop in the wrong slot arriving with a byte, must leave the latch empty. The bench judges that by a later correct stop, which must start no busy window.

// File: rtl/pw_pkg.sv
package pw_pkg;
   typedef enum logic {
      TM_IDLE = 1'b0,
      TM_BUSY = 1'b1
   } tm_state_e;
endpackage

// File: rtl/pw_addr_ptr.sv
module pw_addr_ptr #(
   parameter int ADDR_W     = 13,
   parameter int PAGE_BYTES = 32,
   localparam int IDX_W     = $clog2(PAGE_BYTES),
   localparam int ROW_W     = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [ROW_W-1:0]  row,
   output logic [IDX_W-1:0]  ofs
);
   initial begin : chk_params
      if ((1 << IDX_W) != PAGE_BYTES) $error("PAGE_BYTES must be a power of two");
      if (ADDR_W <= IDX_W) $error("ADDR_W must exceed the offset width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
         ofs <= '0;
      end else if (load) begin
         row <= load_addr[ADDR_W-1:IDX_W];
         ofs <= load_addr[IDX_W-1:0];
      end else if (step) begin
         ofs <= ofs + 1'b1;
      end
   end

   // R2: a step moves the offset by one modulo the page and leaves the row alone
   assert_ofs_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (ofs == IDX_W'($past(ofs) + 1'b1)) && $stable(row));
endmodule

// File: rtl/pw_page_latch.sv
module pw_page_latch #(
   parameter int PAGE_BYTES = 32,
   parameter int DATA_W     = 8,
   localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  clr,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  rd_valid,
   output logic [PAGE_BYTES-1:0] vmask
);
   logic [DATA_W-1:0] dat_arr [PAGE_BYTES];

   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_entry
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else if (clr) begin
            v_q <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            v_q <= 1'b1;
            d_q <= wr_data;
         end
      end
      assign vmask[i]   = v_q;
      assign dat_arr[i] = d_q;
   end

   assign rd_data  = dat_arr[rd_idx];
   assign rd_valid = vmask[rd_idx];

   // R3: a clear leaves every entry empty
   assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (vmask == '0));

   // R1: a store marks its entry valid
   assert_store_marks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> vmask[$past(wr_idx)]);
endmodule

// File: rtl/pw_commit_timer.sv
module pw_commit_timer
   import pw_pkg::*;
#(
   parameter int TW_CYCLES  = 1000,
   parameter int PAGE_BYTES = 32,
   localparam int IDX_W     = $clog2(PAGE_BYTES),
   localparam int CNT_W     = $clog2(TW_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   output logic             busy,
   output logic             done,
   output logic             walk_active,
   output logic [IDX_W-1:0] walk_idx
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TW_CYCLES);
   localparam logic [CNT_W-1:0] WALK = CNT_W'(PAGE_BYTES);

   initial begin : chk_params
      if (TW_CYCLES < PAGE_BYTES) $error("TW_CYCLES must cover the page walk");
   end

   tm_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TM_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            TM_IDLE: if (go) begin
               state_q <= TM_BUSY;
               cnt_q   <= '0;
            end
            TM_BUSY: if (cnt_q == LAST) state_q <= TM_IDLE;
                     else               cnt_q   <= cnt_q + 1'b1;
            default: state_q <= TM_IDLE;
         endcase
      end
   end

   assign busy        = (state_q == TM_BUSY);
   assign done        = busy && (cnt_q == LAST);
   assign walk_active = busy && (cnt_q < WALK);
   assign walk_idx    = cnt_q[IDX_W-1:0];

   // R6: the window always closes after the full count
   assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(cnt_q) == LAST));

   // R6: a window opens only on request
   assert_busy_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(go));
endmodule

// File: rtl/pw_commit_seq.sv
module pw_commit_seq #(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int TW_CYCLES  = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              wp,
   input  logic              stop_in_slot,
   input  logic              stop_other,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata
);
   localparam int IDX_W = $clog2(PAGE_BYTES);
   localparam int ROW_W = ADDR_W - IDX_W;

   logic                  idle, take, keep, load, clr, go, done;
   logic                  walk_active, rd_valid;
   logic [IDX_W-1:0]      walk_idx, ofs;
   logic [ROW_W-1:0]      row;
   logic [PAGE_BYTES-1:0] vmask;
   logic [DATA_W-1:0]     rd_data;

   assign idle = !busy;
   assign take = byte_valid && idle;
   assign keep = take && !wp;
   assign load = cmd_start && idle;
   assign clr  = (idle && (cmd_start || stop_other)) || done;
   assign go   = idle && stop_in_slot && !stop_other && ((|vmask) || keep);

   pw_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(load), .load_addr(start_addr),
      .step(take && !load), .row(row), .ofs(ofs));

   pw_page_latch #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .wr_en(keep), .wr_idx(ofs), .wr_data(byte_data),
      .clr(clr), .rd_idx(walk_idx), .rd_data(rd_data), .rd_valid(rd_valid),
      .vmask(vmask));

   pw_commit_timer #(.TW_CYCLES(TW_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_timer (
      .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
      .walk_active(walk_active), .walk_idx(walk_idx));

   assign arr_we    = walk_active && rd_valid;
   assign arr_addr  = {row, walk_idx};
   assign arr_wdata = rd_data;

   // R7: array strobes stay inside the window and before its last cycle
   assert_we_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> (busy && !done));

   // R7: the latch is empty once the window closes
   assert_done_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (vmask == '0));

   // R4: nothing moves the pointer while busy
   assert_bus_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(ofs) && $stable(row)));

   // R5: protected bytes never enter the latch
   assert_wp_no_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wp && idle && !cmd_start && !stop_other) |=> $stable(vmask));

   // R3: a window only follows a stop in the right slot
   assert_commit_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_in_slot));
endmodule

// File: tb/tb_pw_commit_seq.sv
module tb_pw_commit_seq;
   localparam int AW = 13;
   localparam int TW = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_start = 1'b0, byte_valid = 1'b0, wp = 1'b0;
   logic          stop_in_slot = 1'b0, stop_other = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [7:0]    byte_data = '0;
   logic          busy, arr_we;
   logic [AW-1:0] arr_addr;
   logic [7:0]    arr_wdata;

   int errors = 0, checks = 0, nlog = 0, nbusy = 0;
   logic [AW-1:0] log_a [64];
   logic [7:0]    log_d [64];

   always #4 clk = ~clk;

   pw_commit_seq #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(32), .TW_CYCLES(TW)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
      .byte_valid(byte_valid), .byte_data(byte_data), .wp(wp),
      .stop_in_slot(stop_in_slot), .stop_other(stop_other), .busy(busy),
      .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata));

   always @(negedge clk) if (rst_n) begin
      if (arr_we) begin
         if (nlog < 64) begin
            log_a[nlog] = arr_addr;
            log_d[nlog] = arr_wdata;
         end
         nlog++;
      end
      if (busy) nbusy++;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_eq(input string tag, input int act, input int exp);
      check(act == exp, tag, act, exp);
   endtask

   task automatic do_start(input logic [AW-1:0] a);
      @(negedge clk); cmd_start = 1'b1; start_addr = a;
      @(negedge clk); cmd_start = 1'b0;
   endtask

   task automatic do_byte(input logic [7:0] d);
      @(negedge clk); byte_valid = 1'b1; byte_data = d;
      @(negedge clk); byte_valid = 1'b0;
   endtask

   task automatic do_stop(input bit good);
      @(negedge clk); stop_in_slot = good; stop_other = !good;
      @(negedge clk); stop_in_slot = 1'b0; stop_other = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!busy) break;
      end
   endtask

   task automatic clear_log();
      nlog = 0; nbusy = 0;
   endtask

   task automatic expect_write(input int k, input logic [AW-1:0] a, input logic [7:0] d,
                               input string tag);
      check_eq({tag, " addr"}, int'(log_a[k]), int'(a));
      check_eq({tag, " data"}, int'(log_d[k]), int'(d));
   endtask

   task automatic t_reset();
      check_eq("R9 busy after reset", int'(busy), 0);
      check_eq("R9 arr_we after reset", int'(arr_we), 0);
      clear_log();
      do_stop(1'b1);
      repeat (3) @(negedge clk);
      check_eq("R9 empty latch starts no window", nbusy, 0);
   endtask

   task automatic t_single();
      clear_log();
      do_start(13'h0123);
      do_byte(8'hA5);
      do_stop(1'b1);
      check_eq("R6 busy one cycle after stop", int'(busy), 1);
      wait_idle();
      check_eq("R6 busy length", nbusy, TW + 1);
      check_eq("R1 write count", nlog, 1);
      expect_write(0, 13'h0123, 8'hA5, "R1 single byte");
   endtask

   task automatic t_wrap();
      clear_log();
      do_start(13'h1FFE);
      do_byte(8'h10); do_byte(8'h11); do_byte(8'h12); do_byte(8'h13);
      do_stop(1'b1);
      wait_idle();
      check_eq("R2 wrap write count", nlog, 4);
      expect_write(0, 13'h1FE0, 8'h12, "R2 wrap off0");
      expect_write(1, 13'h1FE1, 8'h13, "R2 wrap off1");
      expect_write(2, 13'h1FFE, 8'h10, "R7 ascending off30");
      expect_write(3, 13'h1FFF, 8'h11, "R7 ascending off31");
   endtask

   task automatic t_overwrite();
      int bad = 0;
      clear_log();
      do_start(13'h0040);
      for (int i = 1; i <= 33; i++) do_byte(8'(i));
      do_stop(1'b1);
      wait_idle();
      check_eq("R2 full page write count", nlog, 32);
      expect_write(0, 13'h0040, 8'h21, "R2 overwrite off0");
      for (int k = 1; k < 32; k++)
         if (log_a[k] != 13'(13'h0040 + k) || log_d[k] != 8'(k + 1)) bad++;
      check_eq("R1 full page contents", bad, 0);
   endtask

   task automatic t_discard();
      clear_log();
      do_start(13'h0100);
      do_byte(8'h01); do_byte(8'h02);
      do_stop(1'b0);
      repeat (3) @(negedge clk);
      check_eq("R3 wrong-slot stop no busy", nbusy, 0);
      do_stop(1'b1);
      repeat (3) @(negedge clk);
      check_eq("R3 discarded latch no busy", nbusy, 0);
      check_eq("R3 discarded latch no write", nlog, 0);
      do_start(13'h0100);
      do_byte(8'h03);
      do_start(13'h0105);
      do_byte(8'h04);
      do_stop(1'b1);
      wait_idle();
      check_eq("R3 restart drops old bytes", nlog, 1);
      expect_write(0, 13'h0105, 8'h04, "R3 restart");
      clear_log();
      do_start(13'h0110);
      @(negedge clk); byte_valid = 1'b1; byte_data = 8'h77; stop_other = 1'b1;
      @(negedge clk); byte_valid = 1'b0; stop_other = 1'b0;
      do_stop(1'b1);
      repeat (3) @(negedge clk);
      check_eq("R3 discard wins over byte", nbusy, 0);
   endtask

   task automatic t_wp();
      clear_log();
      wp = 1'b1;
      do_start(13'h0200);
      do_byte(8'hE1); do_byte(8'hE2);
      do_stop(1'b1);
      repeat (3) @(negedge clk);
      check_eq("R5 protected no busy", nbusy, 0);
      check_eq("R5 protected no write", nlog, 0);
      wp = 1'b0;
      do_start(13'h0220);
      do_byte(8'h55);
      wp = 1'b1; do_byte(8'h66);
      wp = 1'b0; do_byte(8'h77);
      do_stop(1'b1);
      wait_idle();
      check_eq("R5 mixed write count", nlog, 2);
      expect_write(0, 13'h0220, 8'h55, "R5 off0");
      expect_write(1, 13'h0222, 8'h77, "R5 skip protected");
   endtask

   task automatic t_busy_ignore();
      clear_log();
      do_start(13'h0300);
      do_byte(8'h11);
      do_stop(1'b1);
      do_start(13'h0555);
      do_byte(8'h99);
      do_stop(1'b0);
      do_stop(1'b1);
      check_eq("R4 still busy during traffic", int'(busy), 1);
      wait_idle();
      check_eq("R4 only original write", nlog, 1);
      expect_write(0, 13'h0300, 8'h11, "R4 original");
      clear_log();
      do_stop(1'b1);
      repeat (3) @(negedge clk);
      check_eq("R7 latch cleared after commit", nbusy, 0);
      do_byte(8'h22);
      do_stop(1'b1);
      wait_idle();
      check_eq("R4 pointer kept", nlog, 1);
      expect_write(0, 13'h0301, 8'h22, "R4 next offset");
   endtask

   task automatic t_same_cycle();
      clear_log();
      do_start(13'h0400);
      do_byte(8'h31);
      @(negedge clk); byte_valid = 1'b1; byte_data = 8'h32; stop_in_slot = 1'b1;
      @(negedge clk); byte_valid = 1'b0; stop_in_slot = 1'b0;
      check_eq("R8 busy after joint stop", int'(busy), 1);
      wait_idle();
      check_eq("R8 both bytes written", nlog, 2);
      expect_write(0, 13'h0400, 8'h31, "R8 first");
      expect_write(1, 13'h0401, 8'h32, "R8 joint byte");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_wrap();
      t_overwrite();
      t_discard();
      t_wp();
      t_busy_ignore();
      t_same_cycle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule